// File: doc/BRIEF.md
# Program Counter and DMA Address Sequencer

This block produces every memory address a small 16-bit pipelined processor issues. The program counter and a DMA transfer pointer sit together in one small register array. A single read port, one +2 adder and one address output serve both. No second counter or address multiplexer is needed for DMA traffic.

Each pipeline cycle is divided into memory slots that always come in the same order. The instruction fetch is always first. One DMA word follows if a transfer is pending when the fetch completes. A load or store for the execute stage comes last if one is requested. Any slot can be stretched by wait states: it holds until memory signals ready. When the last slot of the pipeline cycle finishes, the block pulses an advance strobe so the pipeline moves on. Branch and jump targets overwrite the program counter through a write port. Software-side logic can reload the DMA pointer through a second write port.

Top module: `dma_pc_addr_unit`

## Requirements
- R1: After reset the block is in the fetch slot, `mem_addr` equals the `RESET_PC` parameter (default 0x0000), `advance` is low, and the DMA pointer reads 0x0000 when first used.
- R2: A fetch slot reports `cyc_type` = 2'b01, drives the program counter (array entry 0) on `mem_addr`, and on completion stores that value plus 2 back into entry 0.
- R3: A DMA slot reports `cyc_type` = 2'b10, drives the DMA pointer (array entry 1) on `mem_addr`, and on completion stores that value plus 2 back into entry 1, wrapping modulo 2^16.
- R4: A DMA slot follows a fetch only when `dma_req` is high in the clock where the fetch completes, and at most one DMA slot occurs per pipeline cycle.
- R5: A load/store slot reports `cyc_type` = 2'b11 and drives `ls_addr`. It follows the fetch or the DMA slot when `ls_req` is high in the clock where that slot completes, and it is always the last slot. The slot order is fetch, DMA, load/store.
- R6: A slot completes only in a clock with `mem_rdy` high. Until then `cyc_type` and `mem_addr` hold, provided no write port is used.
- R7: `advance` is high exactly in the clock where the last slot of a pipeline cycle completes, and is low otherwise.
- R8: `br_we` loads `br_target` into the program counter. In the same clock it takes priority over the fetch increment.
- R9: `dptr_we` loads `dptr_val` into the DMA pointer. In the same clock it takes priority over the DMA increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | 1 | DMA word wanted; sampled when a fetch completes |
| ls_req | input | 1 | Execute-stage load/store wanted; sampled when the fetch or DMA slot completes |
| ls_addr | input | 16 | Effective address for the load/store slot |
| mem_rdy | input | 1 | Current memory slot completes in this clock |
| br_we | input | 1 | Write branch/jump target into the program counter |
| br_target | input | 16 | Branch/jump target address |
| dptr_we | input | 1 | Write the DMA pointer |
| dptr_val | input | 16 | New DMA pointer value |
| mem_addr | output | 16 | Address of the current memory slot |
| cyc_type | output | 2 | Slot tag: 01 fetch, 10 DMA, 11 load/store |
| advance | output | 1 | Pipeline-advance strobe |

## Verification
The assertions check the local slot rules on every clock. These are: the tag is always a legal code; wait states hold the tag and address; advance only comes with ready and is followed by a fetch; a completing load/store returns to fetch; DMA never repeats within a pipeline cycle; a DMA request at fetch completion always yields a DMA slot; and a lone fetch steps the address by two. Three things depend on what happened earlier, so only the bench's scoreboard scenarios can show them. These are the exact address sequences across many pipeline cycles, pointer wrap at the top of memory, and the priority of both write ports over the increment.

// File: rtl/dma_pc_addr_unit.sv
module dma_pc_addr_unit #(
  parameter int AW       = 16,
  parameter int NREGS    = 16,
  parameter int STEP     = 2,
  parameter int RESET_PC = 0,
  parameter int PC_IDX   = 0,
  parameter int DP_IDX   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_req,
  input  logic          ls_req,
  input  logic [AW-1:0] ls_addr,
  input  logic          mem_rdy,
  input  logic          br_we,
  input  logic [AW-1:0] br_target,
  input  logic          dptr_we,
  input  logic [AW-1:0] dptr_val,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    cyc_type,
  output logic          advance
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [IW-1:0] PC_SEL = PC_IDX[IW-1:0];
  localparam logic [IW-1:0] DP_SEL = DP_IDX[IW-1:0];

  typedef enum logic [1:0] {
    S_FETCH = 2'b01,
    S_DMA   = 2'b10,
    S_LS    = 2'b11
  } slot_t;

  slot_t         slot, slot_nx;
  logic [AW-1:0] rf [NREGS];
  logic [IW-1:0] rsel;
  logic [AW-1:0] rd, inc;
  logic          bump;

  assign rsel     = (slot == S_DMA) ? DP_SEL : PC_SEL;
  assign rd       = rf[rsel];
  assign inc      = rd + STEP[AW-1:0];
  assign mem_addr = (slot == S_LS) ? ls_addr : rd;
  assign cyc_type = slot;
  assign bump     = mem_rdy && (slot != S_LS);
  assign advance  = mem_rdy && (slot_nx == S_FETCH);

  always_comb begin
    slot_nx = slot;
    if (mem_rdy) begin
      unique case (slot)
        S_FETCH: slot_nx = dma_req ? S_DMA : (ls_req ? S_LS : S_FETCH);
        S_DMA:   slot_nx = ls_req ? S_LS : S_FETCH;
        default: slot_nx = S_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= S_FETCH;
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
      rf[PC_IDX] <= RESET_PC[AW-1:0];
    end else begin
      slot <= slot_nx;
      if (bump)    rf[rsel]   <= inc;
      if (br_we)   rf[PC_IDX] <= br_target;
      if (dptr_we) rf[DP_IDX] <= dptr_val;
    end
  end
endmodule

module dma_pc_addr_unit_chk #(
  parameter int AW   = 16,
  parameter int STEP = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_req,
  input logic          ls_req,
  input logic          mem_rdy,
  input logic          br_we,
  input logic          dptr_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    cyc_type,
  input logic          advance
);
  // R5
  legal_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_type != 2'b00);
  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rdy && !br_we && !dptr_we && cyc_type != 2'b11)
      |=> (cyc_type == $past(cyc_type) && mem_addr == $past(mem_addr)));
  // R6
  wait_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rdy |=> cyc_type == $past(cyc_type));
  // R7
  adv_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> mem_rdy);
  // R7
  adv_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> cyc_type == 2'b01);
  // R5
  ls_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 2'b11 && mem_rdy) |=> cyc_type == 2'b01);
  // R4
  one_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 2'b10 && mem_rdy) |=> cyc_type != 2'b10);
  // R4
  dma_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 2'b01 && mem_rdy && dma_req) |=> cyc_type == 2'b10);
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 2'b01 && mem_rdy && !dma_req && !ls_req && !br_we)
      |=> mem_addr == $past(mem_addr) + STEP[AW-1:0]);
endmodule

bind dma_pc_addr_unit dma_pc_addr_unit_chk #(.AW(AW), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .ls_req(ls_req),
  .mem_rdy(mem_rdy), .br_we(br_we), .dptr_we(dptr_we),
  .mem_addr(mem_addr), .cyc_type(cyc_type), .advance(advance)
);

// File: tb/dma_pc_addr_unit_test.sv
`timescale 1ns/1ps
module dma_pc_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_req = 1'b0, ls_req = 1'b0, mem_rdy = 1'b0;
  logic        br_we = 1'b0, dptr_we = 1'b0;
  logic [15:0] ls_addr = '0, br_target = '0, dptr_val = '0;
  logic [15:0] mem_addr;
  logic [1:0]  cyc_type;
  logic        advance;

  int checks = 0, failures = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0]  t;
    logic [15:0] a;
    logic        adv;
    string       req;
  } item_t;
  item_t q[$];

  logic [15:0] pc = 16'h0000, dp = 16'h0000;

  always #2.5 clk = ~clk;

  dma_pc_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .ls_req(ls_req),
    .ls_addr(ls_addr), .mem_rdy(mem_rdy), .br_we(br_we),
    .br_target(br_target), .dptr_we(dptr_we), .dptr_val(dptr_val),
    .mem_addr(mem_addr), .cyc_type(cyc_type), .advance(advance)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run && q.size() > 0) begin
      if (mem_rdy) begin
        item_t it;
        it = q.pop_front();
        chk(cyc_type == it.t, it.req, "tag", 32'(cyc_type), 32'(it.t));
        chk(mem_addr == it.a, it.req, "addr", 32'(mem_addr), 32'(it.a));
        chk(advance == it.adv, "R7", "advance", 32'(advance), 32'(it.adv));
      end else begin
        chk(cyc_type == q[0].t && mem_addr == q[0].a, "R6", "wait hold",
            {14'd0, cyc_type, mem_addr}, {14'd0, q[0].t, q[0].a});
        chk(advance == 1'b0, "R7", "advance in wait", 32'(advance), 32'd0);
      end
    end
  end

  task automatic do_slot(input logic [1:0] t, input logic [15:0] a,
                         input bit last, input int waits, input string req,
                         input bit brf, input logic [15:0] brt,
                         input bit dwf, input logic [15:0] dwv);
    item_t it;
    it.t = t; it.a = a; it.adv = last; it.req = req;
    q.push_back(it);
    repeat (waits) begin
      mem_rdy = 1'b0; br_we = 1'b0; dptr_we = 1'b0;
      @(posedge clk); #1;
    end
    mem_rdy = 1'b1;
    br_we = last && brf; br_target = brt;
    dptr_we = last && dwf; dptr_val = dwv;
    @(posedge clk); #1;
    mem_rdy = 1'b0; br_we = 1'b0; dptr_we = 1'b0;
  endtask

  task automatic pcycle(input bit dma, input bit ls, input logic [15:0] lsa,
                        input int wf, input int wd, input int wl,
                        input bit brf, input logic [15:0] brt,
                        input bit dwf, input logic [15:0] dwv);
    dma_req = dma; ls_req = ls; ls_addr = lsa;
    do_slot(2'b01, pc, !dma && !ls, wf, brf ? "R8" : "R2", brf, brt, dwf, dwv);
    pc = pc + 16'd2;
    if (dma) begin
      do_slot(2'b10, dp, !ls, wd, dwf ? "R9" : "R3", brf, brt, dwf, dwv);
      dp = dp + 16'd2;
    end
    if (ls) do_slot(2'b11, lsa, 1'b1, wl, "R5", brf, brt, dwf, dwv);
    if (brf) pc = brt;
    if (dwf) dp = dwv;
    dma_req = 1'b0; ls_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cyc_type == 2'b01, "R1", "reset tag", 32'(cyc_type), 32'd1);
    chk(mem_addr == 16'h0000, "R1", "reset addr", 32'(mem_addr), 32'd0);
    chk(advance == 1'b0, "R1", "reset advance", 32'(advance), 32'd0);
    @(posedge clk); #1;
    run = 1'b1;
    // R2 plain fetches, no waits, then with waits (R6)
    repeat (3) pcycle(0, 0, 16'h0, 0, 0, 0, 0, 16'h0, 0, 16'h0);
    pcycle(0, 0, 16'h0, 3, 0, 0, 0, 16'h0, 0, 16'h0);
    // R1 DMA pointer starts at zero; R3 DMA steps; R4 one DMA per cycle
    pcycle(1, 0, 16'h0, 0, 0, 0, 0, 16'h0, 0, 16'h0);
    pcycle(1, 0, 16'h0, 1, 2, 0, 0, 16'h0, 0, 16'h0);
    // R5 load/store alone and after DMA, with waits
    pcycle(0, 1, 16'h4A20, 0, 0, 0, 0, 16'h0, 0, 16'h0);
    pcycle(1, 1, 16'h8001, 2, 1, 3, 0, 16'h0, 0, 16'h0);
    // R8 branch on a lone fetch completion (priority over +2) and at load/store end
    pcycle(0, 0, 16'h0, 0, 0, 0, 1, 16'h1230, 0, 16'h0);
    pcycle(0, 0, 16'h0, 1, 0, 0, 0, 16'h0, 0, 16'h0);
    pcycle(0, 1, 16'h0100, 0, 0, 1, 1, 16'h0800, 0, 16'h0);
    pcycle(0, 0, 16'h0, 0, 0, 0, 0, 16'h0, 0, 16'h0);
    // R9 pointer load on DMA completion, then R3 wrap from 0xFFFE
    pcycle(1, 0, 16'h0, 0, 0, 0, 0, 16'h0, 1, 16'hFFFE);
    pcycle(1, 0, 16'h0, 0, 0, 0, 0, 16'h0, 0, 16'h0);
    pcycle(1, 0, 16'h0, 0, 1, 0, 0, 16'h0, 0, 16'h0);
    // R9 pointer load during a fetch-only cycle
    pcycle(0, 0, 16'h0, 0, 0, 0, 0, 16'h0, 1, 16'h3000);
    pcycle(1, 1, 16'hC0DE, 0, 0, 0, 0, 16'h0, 0, 16'h0);
    // mixed traffic
    for (int i = 0; i < 40; i++) begin
      int unsigned r;
      r = $urandom();
      pcycle(r[0], r[1], r[31:16], int'(r[3:2]), int'(r[5:4]), int'(r[7:6]),
             r[8] && r[9], {r[23:17], 9'h0}, r[10] && r[11], r[27:12]);
    end
    @(negedge clk);
    chk(q.size() == 0, "R7", "scoreboard drained", 32'(q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R7 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule